// File: doc/BRIEF.md
# Output-stationary systolic GEMM array

The block computes one tile of a signed integer matrix product, C = bias + A·B, on an H×W grid of multiply-accumulate cells. A is an H×K tile of an im2col-flattened activation matrix, one row per grid row. B is a K×W tile of flattened filters or fully connected weights, one column per grid column. Each cell keeps its own 32-bit accumulator for the whole tile and never writes it back while the tile runs. A operands travel right and B operands travel down, one cell per cycle. Edge delay lines hold back grid row i by i cycles and grid column j by j cycles, so A[i][k] and B[k][j] arrive in cell (i,j) in the same cycle.

The accumulators also form a vertical shift chain, and this chain carries both the preload and the readout. Each idle shift moves every row down by one. The bottom row appears at the output, and a new bias row enters at the top. H shifts therefore read out a finished tile and preload the biases or partial sums of the next tile at the same time. A start command sets the reduction length K. The block then asks for operands during K feed cycles and zeroes its edges for the fill and drain cycles. It raises done when the last product has been accumulated.

Top module: `os_gemm_array`

## Requirements
- R1: After reset, every accumulator is zero and busy_o, done_o, feed_o and out_valid_o are low.
- R2: An accepted shift (shift_i high while idle and start_i low) does four things in the same cycle. It presents the bottom row's accumulators on out_row_o, with column j at bits [j*32 +: 32], and raises out_valid_o. It moves every row down by one. It loads bias_row_i into row 0. So the bias given on shift s of a run of H shifts ends in row H-1-s, and the bottom row is read first.
- R3: An accepted start (start_i high while idle) samples k_len_i as K and sets busy_o. feed_o is then high for exactly the first K cycles. In feed cycle k, a_col_i[i*8 +: 8] carries A[i][k] and b_row_i[j*8 +: 8] carries B[k][j].
- R4: When a tile finishes, accumulator (i,j) equals its preloaded value plus the sum over k of A[i][k]·B[k][j]. Operands are signed 8-bit two's complement, and the sum wraps modulo 2^32.
- R5: done_o rises, and busy_o falls, K+H+W-2 cycles after the cycle that accepted the start. done_o then stays high until the next accepted start or shift.
- R6: a_col_i and b_row_i have no effect outside feed cycles, because the edges take zero in the fill and drain cycles. Once the block has been idle for a cycle, the operand registers at the right and bottom edges read zero.
- R7: start_i and shift_i are ignored while busy_o is high. Out_valid_o stays low, and K and the running tile are unchanged. When start and shift arrive together while idle, the start wins.
- R8: While idle with no shift, the accumulators hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | start a tile (idle only) |
| k_len_i | input | KW | reduction length K |
| a_col_i | input | H*DW | A column k, row i in lane i |
| b_row_i | input | W*DW | B row k, column j in lane j |
| shift_i | input | 1 | readout/preload shift (idle only) |
| bias_row_i | input | W*PW | row entering the top of the accumulator chain |
| busy_o | output | 1 | tile in progress |
| feed_o | output | 1 | operands are consumed this cycle |
| done_o | output | 1 | tile finished, results valid |
| out_valid_o | output | 1 | out_row_o carries a row this cycle |
| out_row_o | output | W*PW | bottom-row accumulators |

## Verification
The assertions assume that the default H+W-2 fits in KW bits. They also assume that shifts and starts are only meaningful while idle, so the rule that shifts and starts are ignored while busy is checked as a property, not assumed. The edge-clearing property relies on every tile ending with its full drain before the next start. This always holds, because the controller never cuts a drain short. The bench keeps to these limits by using a 3×4 grid with K from 0 to 9. It sweeps mixed-sign patterns, extreme operands of -128 and 127, and a bias next to the positive limit, which forces wraparound. It drives garbage outside the feed cycles, and it issues a start and a shift in mid-tile.

// File: rtl/os_gemm_pkg.sv
package os_gemm_pkg;
  localparam int unsigned OPND_W_DEF = 8;
  localparam int unsigned ACC_W_DEF  = 32;
  localparam int unsigned GRID_DEF   = 8;
  localparam int unsigned KLEN_W_DEF = 16;
endpackage

// File: rtl/os_gemm_skew.sv
module os_gemm_skew #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  if (DEPTH == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_line
    logic [DW-1:0] stage_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int n = 0; n < DEPTH; n++) stage_q[n] <= '0;
      end else if (en_i) begin
        stage_q[0] <= d_i;
        for (int n = 1; n < DEPTH; n++) stage_q[n] <= stage_q[n-1];
      end
    end
    assign q_o = stage_q[DEPTH-1];
  end
endmodule

// File: rtl/os_gemm_pe.sv
module os_gemm_pe #(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic                 shift_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic        [PW-1:0] psum_i,
  output logic signed [DW-1:0] a_o,
  output logic signed [DW-1:0] b_o,
  output logic        [PW-1:0] psum_o
);
  logic signed [2*DW-1:0] prod;
  logic        [PW-1:0]   acc_q;

  assign prod = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o   <= '0;
      b_o   <= '0;
      acc_q <= '0;
    end else begin
      // operand regs drop to zero when idle
      a_o <= step_i ? a_i : '0;
      b_o <= step_i ? b_i : '0;
      if (step_i)       acc_q <= acc_q + PW'(prod);
      else if (shift_i) acc_q <= psum_i;
    end
  end

  assign psum_o = acc_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !shift_i) |=> $stable(psum_o));
endmodule

// File: rtl/os_gemm_ctrl.sv
module os_gemm_ctrl #(
  parameter int unsigned KW = 16,
  parameter int unsigned H  = 8,
  parameter int unsigned W  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [KW-1:0] k_len_i,
  input  logic          shift_i,
  output logic          busy_o,
  output logic          feed_o,
  output logic          shift_o,
  output logic          done_o
);
  localparam int unsigned CW = KW + 1;

  logic [CW-1:0] cnt_q, total_q;
  logic [KW-1:0] klen_q;
  logic          take_start;

  assign take_start = start_i && !busy_o;
  assign shift_o    = shift_i && !busy_o && !start_i;
  assign feed_o     = busy_o && (cnt_q < {1'b0, klen_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      cnt_q   <= '0;
      total_q <= '0;
      klen_q  <= '0;
    end else if (take_start) begin
      busy_o  <= 1'b1;
      done_o  <= 1'b0;
      cnt_q   <= '0;
      klen_q  <= k_len_i;
      total_q <= CW'(k_len_i) + CW'(H + W - 2);
    end else if (busy_o) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q + CW'(1) >= total_q) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end else if (shift_o) begin
      done_o <= 1'b0;
    end
  end

  p_done_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(klen_q));
  p_feed_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_start && k_len_i != '0) |=> feed_o);
endmodule

// File: rtl/os_gemm_array.sv
module os_gemm_array
  import os_gemm_pkg::*;
#(
  parameter int unsigned H  = GRID_DEF,
  parameter int unsigned W  = GRID_DEF,
  parameter int unsigned DW = OPND_W_DEF,
  parameter int unsigned PW = ACC_W_DEF,
  parameter int unsigned KW = KLEN_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [KW-1:0]   k_len_i,
  input  logic [H*DW-1:0] a_col_i,
  input  logic [W*DW-1:0] b_row_i,
  input  logic            shift_i,
  input  logic [W*PW-1:0] bias_row_i,
  output logic            busy_o,
  output logic            feed_o,
  output logic            done_o,
  output logic            out_valid_o,
  output logic [W*PW-1:0] out_row_o
);
  logic shift_ok;

  logic signed [DW-1:0] a_bus [H][W+1];
  logic signed [DW-1:0] b_bus [H+1][W];
  logic        [PW-1:0] ps    [H][W];
  logic        [PW-1:0] pin   [H][W];

  os_gemm_ctrl #(.KW(KW), .H(H), .W(W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .k_len_i, .shift_i,
    .busy_o, .feed_o, .shift_o(shift_ok), .done_o
  );

  for (genvar i = 0; i < H; i++) begin : g_row_skew
    os_gemm_skew #(.DW(DW), .DEPTH(i)) u_skew (
      .clk_i, .rst_ni, .en_i(busy_o),
      .d_i(feed_o ? a_col_i[i*DW +: DW] : '0),
      .q_o(a_bus[i][0])
    );
  end

  for (genvar j = 0; j < W; j++) begin : g_col_skew
    os_gemm_skew #(.DW(DW), .DEPTH(j)) u_skew (
      .clk_i, .rst_ni, .en_i(busy_o),
      .d_i(feed_o ? b_row_i[j*DW +: DW] : '0),
      .q_o(b_bus[0][j])
    );
  end

  for (genvar i = 0; i < H; i++) begin : g_r
    for (genvar j = 0; j < W; j++) begin : g_c
      if (i == 0) begin : g_top
        assign pin[i][j] = bias_row_i[j*PW +: PW];
      end else begin : g_mid
        assign pin[i][j] = ps[i-1][j];
      end
      os_gemm_pe #(.DW(DW), .PW(PW)) u_pe (
        .clk_i, .rst_ni,
        .step_i (busy_o),
        .shift_i(shift_ok),
        .a_i    (a_bus[i][j]),
        .b_i    (b_bus[i][j]),
        .psum_i (pin[i][j]),
        .a_o    (a_bus[i][j+1]),
        .b_o    (b_bus[i+1][j]),
        .psum_o (ps[i][j])
      );
    end
  end

  for (genvar j = 0; j < W; j++) begin : g_out
    assign out_row_o[j*PW +: PW] = ps[H-1][j];
  end
  assign out_valid_o = shift_ok;

  p_read_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !busy_o);

  for (genvar i = 0; i < H; i++) begin : g_chk_right
    p_edge_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && $past(!busy_o)) |-> (a_bus[i][W] == '0));
  end
  for (genvar j = 0; j < W; j++) begin : g_chk_bot
    p_edge_clear_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && $past(!busy_o)) |-> (b_bus[H][j] == '0));
    if (H > 1) begin : g_chain
      p_row_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |=> (ps[H-1][j] == $past(ps[H-2][j])));
    end
  end
endmodule

// File: tb/tb_os_gemm_array.sv
module tb_os_gemm_array;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 3;
  localparam int W  = 4;
  localparam int DW = 8;
  localparam int PW = 32;
  localparam int KW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [KW-1:0]   k_len_i = '0;
  logic [H*DW-1:0] a_col_i = '0;
  logic [W*DW-1:0] b_row_i = '0;
  logic            shift_i = 1'b0;
  logic [W*PW-1:0] bias_row_i = '0;
  logic            busy_o, feed_o, done_o, out_valid_o;
  logic [W*PW-1:0] out_row_o;

  os_gemm_array #(.H(H), .W(W), .DW(DW), .PW(PW), .KW(KW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .k_len_i, .a_col_i, .b_row_i,
    .shift_i, .bias_row_i, .busy_o, .feed_o, .done_o, .out_valid_o, .out_row_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int exp_q [H][W];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int a_val(int seed, int i, int k);
    logic [7:0] t;
    if (seed == 7) return -128;
    if (seed == 5) return 127;
    t = 8'(seed*37 + i*11 + k*5 + 3);
    return int'($signed(t));
  endfunction

  function automatic int b_val(int seed, int k, int j);
    logic [7:0] t;
    if (seed == 7) return (j % 2 == 1) ? 127 : -128;
    if (seed == 5) return 127;
    t = 8'(seed*53 - k*13 + j*29 + 1);
    return int'($signed(t));
  endfunction

  function automatic int bias_v(int seed, int i, int j);
    if (seed == 5) return 32'h7FFF_FF00 + i*3 + j;
    return seed*100003 - i*7001 + j*313 - 40000;
  endfunction

  // H shifts: check rows bottom first, load bias of nseed
  task automatic readout(input int nseed, input string req);
    for (int s = 0; s < H; s++) begin
      int bad_j;
      @(negedge clk);
      shift_i = 1'b1;
      for (int j = 0; j < W; j++) bias_row_i[j*PW +: PW] = bias_v(nseed, H-1-s, j);
      #1;
      chk(out_valid_o === 1'b1, "R2 out_valid", int'(out_valid_o), 1);
      bad_j = -1;
      for (int j = W-1; j >= 0; j--)
        if (int'(out_row_o[j*PW +: PW]) != exp_q[H-1-s][j]) bad_j = j;
      if (bad_j < 0) chk(1'b1, req, 0, 0);
      else chk(1'b0, req, int'(out_row_o[bad_j*PW +: PW]), exp_q[H-1-s][bad_j]);
    end
    @(negedge clk);
    shift_i = 1'b0;
    #1;
    chk(done_o === 1'b0 && out_valid_o === 1'b0, "R5 done cleared by shift", int'(done_o), 0);
  endtask

  task automatic run_tile(input int seed, input int kl);
    int m, done_at, feed_bad, tot;
    tot = kl + H + W - 2;
    for (int i = 0; i < H; i++)
      for (int j = 0; j < W; j++) begin
        exp_q[i][j] = bias_v(seed, i, j);
        for (int k = 0; k < kl; k++) exp_q[i][j] += a_val(seed, i, k) * b_val(seed, k, j);
      end
    @(negedge clk);
    start_i = 1'b1;
    k_len_i = KW'(kl);
    m = 0; done_at = -1; feed_bad = 0;
    while (done_at < 0 && m < 200) begin
      @(negedge clk);
      m++;
      start_i = 1'b0;
      shift_i = 1'b0;
      if (done_o) done_at = m;
      if (m <= tot && feed_o !== (m <= kl)) feed_bad++;
      if (feed_o) begin
        for (int i = 0; i < H; i++) a_col_i[i*DW +: DW] = DW'(a_val(seed, i, m-1));
        for (int j = 0; j < W; j++) b_row_i[j*DW +: DW] = DW'(b_val(seed, m-1, j));
      end else begin
        a_col_i = {H{8'h6B}} ^ H*DW'(m);
        b_row_i = {W{8'h9D}} ^ W*DW'(m);
      end
      if (m == 2) begin
        start_i = 1'b1;
        k_len_i = 8'd50;
        shift_i = 1'b1;
        #1;
        chk(out_valid_o === 1'b0, "R7 shift ignored while busy", int'(out_valid_o), 0);
      end
    end
    chk(done_at == tot + 1, "R5 done latency", done_at - 1, tot);
    chk(feed_bad == 0, "R3 feed window", feed_bad, 0);
    repeat (2) @(negedge clk);
    chk(done_o === 1'b1 && busy_o === 1'b0, "R5 done held while idle", int'(done_o), 1);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int seeds [6] = '{1, 2, 3, 4, 7, 5};
    int klens [6] = '{1, 4, 0, 9, 6, 3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy_o === 1'b0 && done_o === 1'b0 && feed_o === 1'b0, "R1 reset flags", int'(busy_o), 0);
    chk(out_valid_o === 1'b0, "R1 reset out_valid", int'(out_valid_o), 0);
    for (int i = 0; i < H; i++) for (int j = 0; j < W; j++) exp_q[i][j] = 0;
    readout(seeds[0], "R1 reset accumulators zero");
    for (int t = 0; t < 6; t++) begin
      run_tile(seeds[t], klens[t]);
      repeat (3) @(negedge clk);  // idle hold
      readout((t < 5) ? seeds[t+1] : 0,
              (seeds[t] == 5) ? "R4 wraparound result" : "R4 R6 R8 tile result");
    end
    report();
  end
endmodule